// File: doc/BRIEF.md
# Early-Late Symbol Timing Adjuster

This block sits in the timing recovery path of a GFSK receiver. It decides when the symbol sampling point should move by one sample, either forward or backward. On every symbol strobe it receives two correlation sums: an early one taken one sample ahead of the current point and a late one taken one sample behind. It tests them against a programmable threshold. If the test passes and every enabled gate agrees, it emits a one-clock pulse that moves the sampling point toward the larger sum.

The gates are as follows:
- The measured RSSI must be above a 7-bit threshold.
- Optionally, a matched-filter average must be above its own threshold.
- The current packet phase must permit an adjustment. The phase is tracked from three strobes: preamble done, access-address match and packet end.

In fast mode, adjustments happen only during acquisition, before the access address matches. In slow mode, adjustments happen only after the match, and they are paced by a symbol counter. A separate bit can stop all adjustment once the preamble ends.

Top module: `el_timing_ctrl`

## Requirements
- R1: `thr_met` is updated on each symbol strobe and holds between strobes. With `cfg_both`=1 it is 1 only when both `early_sum` and `late_sum` are strictly greater than `sum_thr`. With `cfg_both`=0 it is 1 when at least one of them is.
- R2: No adjust pulse is produced for a symbol whose `thr_met` result is 0.
- R3: An adjust pulse appears in the cycle after the accepted strobe and is one clock wide. `adj_fwd` is produced when `late_sum` > `early_sum`, and `adj_bwd` is produced when `early_sum` > `late_sum`. Equal sums produce no pulse. The two pulses are never high together.
- R4: No pulse is produced unless `rssi` > `rssi_thr` (strict), for any threshold in the range 0x00 to 0x7F.
- R5: With `cfg_mf_gate`=1, a pulse also requires `mf_avg` > `mf_thr`. With `cfg_mf_gate`=0, `mf_avg` has no effect.
- R6: With `cfg_slow`=0, pulses are produced only while no access-address match has been seen in the current packet.
- R7: With `cfg_slow`=1, pulses are produced only after an access-address match. A slow counter counts the strobes seen after the match, and a pulse may fire only on a strobe where the counter equals `slow_thr`. On that strobe the counter returns to 0; on other such strobes it increments. With `slow_thr`=2, the third, sixth, ninth and later eligible strobes may fire.
- R8: With `cfg_stop_pre`=1, no pulse is produced once preamble-done has been seen in the packet. With `cfg_stop_pre`=0, the preamble end does not stop adjustment.
- R9: Both synchronous reset (`rst_n`=0) and `pkt_end` clear the following state: the preamble flag, the access-address flag, the slow counter, `thr_met` and both pulses. All outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_stb | input | 1 | Symbol strobe; qualifies the sums and averages |
| early_sum | input | SUM_W | Early correlation sum |
| late_sum | input | SUM_W | Late correlation sum |
| sum_thr | input | SUM_W | Early/late sum threshold |
| mf_avg | input | MF_W | Matched-filter average |
| mf_thr | input | MF_W | Matched-filter average threshold |
| rssi | input | RSSI_W | Measured signal strength |
| rssi_thr | input | RSSI_W | Signal strength threshold |
| pre_done | input | 1 | Preamble finished strobe |
| aa_match | input | 1 | Access-address match strobe |
| pkt_end | input | 1 | End of packet strobe |
| cfg_both | input | 1 | 1: both sums must pass the threshold; 0: either sum |
| cfg_slow | input | 1 | Enables counter-paced tracking after address match |
| cfg_stop_pre | input | 1 | 1: adjustment stops at preamble end |
| cfg_mf_gate | input | 1 | Adds the matched-filter gate |
| slow_thr | input | CNT_W | Slow tracking pace |
| adj_fwd | output | 1 | Move the sampling point one sample later |
| adj_bwd | output | 1 | Move the sampling point one sample earlier |
| thr_met | output | 1 | Result of the latest early/late threshold test |

## Verification
The checker assumes the sums, averages and RSSI inputs are stable and meaningful in the cycle `sym_stb` is high. It checks each pulse against the `$past` values of those inputs. It also assumes that configuration and thresholds change only between symbols. The bench follows both assumptions by driving every input on the falling edge and raising `sym_stb` for single cycles only. It never places a phase strobe in the same cycle as a symbol strobe and changes configuration only while the strobe is low.

// File: rtl/el_timing_ctrl.sv
module el_timing_ctrl #(
  parameter int SUM_W  = 12,
  parameter int MF_W   = 10,
  parameter int RSSI_W = 7,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_stb,
  input  logic [SUM_W-1:0]  early_sum,
  input  logic [SUM_W-1:0]  late_sum,
  input  logic [SUM_W-1:0]  sum_thr,
  input  logic [MF_W-1:0]   mf_avg,
  input  logic [MF_W-1:0]   mf_thr,
  input  logic [RSSI_W-1:0] rssi,
  input  logic [RSSI_W-1:0] rssi_thr,
  input  logic              pre_done,
  input  logic              aa_match,
  input  logic              pkt_end,
  input  logic              cfg_both,
  input  logic              cfg_slow,
  input  logic              cfg_stop_pre,
  input  logic              cfg_mf_gate,
  input  logic [CNT_W-1:0]  slow_thr,
  output logic              adj_fwd,
  output logic              adj_bwd,
  output logic              thr_met
);

  logic             post_pre, post_aa;
  logic [CNT_W-1:0] slow_cnt;

  wire early_hi = early_sum > sum_thr;
  wire late_hi  = late_sum > sum_thr;
  wire met_now  = cfg_both ? (early_hi && late_hi) : (early_hi || late_hi);

  wire phase_ok = (cfg_slow ? post_aa : !post_aa) && !(cfg_stop_pre && post_pre);
  wire pace_hit = slow_cnt == slow_thr;
  wire pace_ok  = !cfg_slow || pace_hit;
  wire level_ok = (rssi > rssi_thr) && (!cfg_mf_gate || mf_avg > mf_thr);
  wire fire     = sym_stb && met_now && level_ok && phase_ok && pace_ok;
  wire cnt_step = sym_stb && cfg_slow && post_aa;

  always_ff @(posedge clk) begin
    if (!rst_n || pkt_end) begin
      post_pre <= 1'b0;
      post_aa  <= 1'b0;
      slow_cnt <= '0;
      thr_met  <= 1'b0;
      adj_fwd  <= 1'b0;
      adj_bwd  <= 1'b0;
    end else begin
      if (pre_done) post_pre <= 1'b1;
      if (aa_match) post_aa <= 1'b1;
      if (sym_stb) thr_met <= met_now;
      if (cnt_step) slow_cnt <= pace_hit ? '0 : slow_cnt + 1'b1;
      adj_fwd <= fire && (late_sum > early_sum);
      adj_bwd <= fire && (early_sum > late_sum);
    end
  end

endmodule

// File: rtl/el_timing_chk.sv
module el_timing_chk #(
  parameter int SUM_W  = 12,
  parameter int MF_W   = 10,
  parameter int RSSI_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sym_stb,
  input logic [SUM_W-1:0]  early_sum,
  input logic [SUM_W-1:0]  late_sum,
  input logic [MF_W-1:0]   mf_avg,
  input logic [MF_W-1:0]   mf_thr,
  input logic [RSSI_W-1:0] rssi,
  input logic [RSSI_W-1:0] rssi_thr,
  input logic              cfg_mf_gate,
  input logic              adj_fwd,
  input logic              adj_bwd,
  input logic              thr_met
);

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(adj_fwd && adj_bwd)); // R3
  AST_PULSE_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_fwd || adj_bwd) |-> $past(sym_stb)); // R3
  AST_FWD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    adj_fwd |-> $past(late_sum > early_sum)); // R3
  AST_BWD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    adj_bwd |-> $past(early_sum > late_sum)); // R3
  AST_NEEDS_MET: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_fwd || adj_bwd) |-> thr_met); // R2
  AST_RSSI_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_fwd || adj_bwd) |-> $past(rssi > rssi_thr)); // R4
  AST_MF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((adj_fwd || adj_bwd) && $past(cfg_mf_gate)) |-> $past(mf_avg > mf_thr)); // R5

endmodule

bind el_timing_ctrl el_timing_chk #(.SUM_W(SUM_W), .MF_W(MF_W), .RSSI_W(RSSI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .early_sum(early_sum),
  .late_sum(late_sum), .mf_avg(mf_avg), .mf_thr(mf_thr), .rssi(rssi),
  .rssi_thr(rssi_thr), .cfg_mf_gate(cfg_mf_gate), .adj_fwd(adj_fwd),
  .adj_bwd(adj_bwd), .thr_met(thr_met)
);

// File: tb/sim_el_timing_ctrl.sv
module sim_el_timing_ctrl;
  localparam int SUM_W = 12, MF_W = 10, RSSI_W = 7, CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_stb = 1'b0;
  logic [SUM_W-1:0] early_sum = '0, late_sum = '0, sum_thr = 12'd100;
  logic [MF_W-1:0] mf_avg = 10'd50, mf_thr = 10'd20;
  logic [RSSI_W-1:0] rssi = 7'd80, rssi_thr = 7'd40;
  logic pre_done = 1'b0, aa_match = 1'b0, pkt_end = 1'b0;
  logic cfg_both = 1'b0, cfg_slow = 1'b0, cfg_stop_pre = 1'b0, cfg_mf_gate = 1'b0;
  logic [CNT_W-1:0] slow_thr = '0;
  logic adj_fwd, adj_bwd, thr_met;

  int checks = 0, fails = 0;
  logic got_f, got_b, got_m;

  always #2.5 clk = ~clk;

  el_timing_ctrl #(.SUM_W(SUM_W), .MF_W(MF_W), .RSSI_W(RSSI_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .early_sum(early_sum),
    .late_sum(late_sum), .sum_thr(sum_thr), .mf_avg(mf_avg), .mf_thr(mf_thr),
    .rssi(rssi), .rssi_thr(rssi_thr), .pre_done(pre_done), .aa_match(aa_match),
    .pkt_end(pkt_end), .cfg_both(cfg_both), .cfg_slow(cfg_slow),
    .cfg_stop_pre(cfg_stop_pre), .cfg_mf_gate(cfg_mf_gate), .slow_thr(slow_thr),
    .adj_fwd(adj_fwd), .adj_bwd(adj_bwd), .thr_met(thr_met)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sym(input int e, input int l);
    @(negedge clk);
    early_sum = SUM_W'(e);
    late_sum = SUM_W'(l);
    sym_stb = 1'b1;
    @(negedge clk);
    sym_stb = 1'b0;
    got_f = adj_fwd;
    got_b = adj_bwd;
    got_m = thr_met;
  endtask

  task automatic pulse_evt(input int which);
    @(negedge clk);
    case (which)
      0: pre_done = 1'b1;
      1: aa_match = 1'b1;
      default: pkt_end = 1'b1;
    endcase
    @(negedge clk);
    pre_done = 1'b0;
    aa_match = 1'b0;
    pkt_end = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 reset fwd", int'(adj_fwd), 0);
    chk("R9 reset bwd", int'(adj_bwd), 0);
    chk("R9 reset met", int'(thr_met), 0);
  endtask

  task automatic t_compare;
    cfg_both = 1'b0;
    sym(150, 50);
    chk("R1 or-mode met", int'(got_m), 1);
    chk("R3 backward", int'(got_b), 1);
    chk("R3 no fwd", int'(got_f), 0);
    @(negedge clk);
    chk("R3 one clock wide", int'(adj_bwd), 0);
    chk("R1 met holds", int'(thr_met), 1);
    sym(50, 60);
    chk("R1 or-mode neither", int'(got_m), 0);
    chk("R2 no pulse without met", int'(got_f), 0);
    cfg_both = 1'b1;
    sym(150, 50);
    chk("R1 and-mode one only", int'(got_m), 0);
    chk("R2 and-mode no pulse", int'(got_b), 0);
    sym(150, 200);
    chk("R1 and-mode both", int'(got_m), 1);
    chk("R3 forward", int'(got_f), 1);
    sym(100, 200);
    chk("R1 equal to thr not above", int'(got_m), 0);
    sym(170, 170);
    chk("R3 equal met", int'(got_m), 1);
    chk("R3 equal no fwd", int'(got_f), 0);
    chk("R3 equal no bwd", int'(got_b), 0);
    cfg_both = 1'b0;
  endtask

  task automatic t_rssi;
    rssi_thr = 7'h7F; rssi = 7'h7F;
    sym(50, 200);
    chk("R4 top threshold blocks", int'(got_f), 0);
    rssi_thr = 7'h00; rssi = 7'h00;
    sym(50, 200);
    chk("R4 zero equal blocks", int'(got_f), 0);
    rssi = 7'h01;
    sym(50, 200);
    chk("R4 above zero passes", int'(got_f), 1);
    rssi_thr = 7'h7E; rssi = 7'h7F;
    sym(200, 50);
    chk("R4 above 0x7E passes", int'(got_b), 1);
    rssi = 7'd80; rssi_thr = 7'd40;
  endtask

  task automatic t_mf;
    cfg_mf_gate = 1'b1; mf_avg = 10'd20; mf_thr = 10'd20;
    sym(50, 200);
    chk("R5 mf equal blocks", int'(got_f), 0);
    mf_avg = 10'd21;
    sym(50, 200);
    chk("R5 mf above passes", int'(got_f), 1);
    cfg_mf_gate = 1'b0; mf_avg = 10'd0;
    sym(50, 200);
    chk("R5 mf ignored when off", int'(got_f), 1);
    mf_avg = 10'd50;
  endtask

  task automatic t_fast;
    pulse_evt(2);
    cfg_slow = 1'b0;
    sym(200, 50);
    chk("R6 before match", int'(got_b), 1);
    pulse_evt(1);
    sym(200, 50);
    chk("R6 after match blocked", int'(got_b), 0);
    chk("R6 met still reported", int'(got_m), 1);
    pulse_evt(2);
    chk("R9 pkt_end clears met", int'(thr_met), 0);
    sym(200, 50);
    chk("R9 match flag cleared", int'(got_b), 1);
  endtask

  task automatic t_slow;
    pulse_evt(2);
    cfg_slow = 1'b1; slow_thr = 4'd2;
    sym(50, 200);
    chk("R7 blocked before match", int'(got_f), 0);
    pulse_evt(1);
    for (int i = 1; i <= 6; i++) begin
      sym(50, 200);
      chk($sformatf("R7 pace strobe %0d", i), int'(got_f), (i % 3 == 0) ? 1 : 0);
    end
    sym(50, 200);
    sym(50, 200);
    pulse_evt(2);
    pulse_evt(1);
    sym(50, 200);
    chk("R9 counter cleared by pkt_end", int'(got_f), 0);
    sym(50, 200);
    sym(50, 200);
    chk("R7 third after new match", int'(got_f), 1);
    slow_thr = 4'd0;
    sym(200, 50);
    chk("R7 zero pace every strobe", int'(got_b), 1);
    sym(200, 50);
    chk("R7 zero pace again", int'(got_b), 1);
    pulse_evt(2);
    cfg_slow = 1'b0;
  endtask

  task automatic t_stop;
    cfg_stop_pre = 1'b1;
    sym(50, 200);
    chk("R8 before preamble end", int'(got_f), 1);
    pulse_evt(0);
    sym(50, 200);
    chk("R8 stops after preamble", int'(got_f), 0);
    pulse_evt(2);
    cfg_stop_pre = 1'b0;
    pulse_evt(0);
    sym(50, 200);
    chk("R8 continues when bit clear", int'(got_f), 1);
    pulse_evt(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_compare();
    t_rssi();
    t_mf();
    t_fast();
    t_slow();
    t_stop();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule